// File: doc/BRIEF.md
# Perpetual Calendar Time Counter

This block keeps wall-clock time and calendar date from a single enable pulse that arrives once per second. It holds seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week count, all as packed BCD except the weekday, which is a small binary count. Each stage only advances when the stage beneath it rolls over, so the minute register is enabled at most once a minute, the hour register once an hour, and so on up to the year.

A host-side serial link (outside this block) drives a parallel load port that overwrites every field in one cycle. Hours can be presented in 24-hour or 12-hour form with an AM/PM flag. The hour is stored internally in 24-hour form, so changing the mode input changes only how the hour is presented, never the time kept. Month lengths and the leap-year rule for February are applied in hardware, with the leap-year decision taken from the two-digit year alone.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 in 24-hour mode (12 with the PM flag at 0 in 12-hour mode), day 01, month 01, year 00 and weekday 0.
- R2: Seconds are BCD 00 to 59 and advance by one on each cycle where `tick_i` is 1 and `load_i` is 0. After 59 they return to 00 and carry into the minutes.
- R3: Minutes are BCD 00 to 59 and change only on a seconds carry. After 59 they return to 00 and carry into the hour.
- R4: In 24-hour mode (`mode12_i` = 0) `hour_o` is BCD 00 to 23 and changes only on a minutes carry. After 23 it returns to 00 and carries into the day and the weekday.
- R5: In 12-hour mode `hour_o` shows BCD 12, 01 through 11. `pm_o` is 1 for the second half of the day. It goes from 0 to 1 when 11 AM becomes 12 PM, and from 1 to 0 when 11 PM becomes 12 AM.
- R6: Changing `mode12_i` changes only the presented hour. No field, including `pm_o`, changes, and switching back restores the previous reading.
- R7: The day of month runs from 01 to the month length: 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. After the last day it returns to 01 and the month advances.
- R8: February has 29 days when the two-digit year is divisible by 4 (00 included) and 28 days otherwise.
- R9: The month runs 01 to 12. After 12 it returns to 01 and the year advances. The year runs 00 to 99 and returns to 00 after 99.
- R10: The weekday runs 0 to 6, advances on the same carry as the day of month, and returns to 0 after 6.
- R11: When `load_i` is 1, every field takes the load port value on the next edge, even if `tick_i` is 1 in the same cycle. In 12-hour mode the loaded hour is read as BCD 01 to 12 qualified by `ld_pm_i`. In 24-hour mode it is read as BCD 00 to 23 and `ld_pm_i` is ignored.
- R12: With `tick_i` and `load_i` both 0, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second enable pulse |
| mode12_i | input | 1 | 1 selects 12-hour presentation |
| load_i | input | 1 | Load all fields from the load port |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hour_i | input | 8 | Hour to load, BCD, in the current mode's form |
| ld_pm_i | input | 1 | PM qualifier for a 12-hour load |
| ld_day_i | input | 8 | Day of month to load, BCD |
| ld_wday_i | input | WD_W (3) | Weekday to load |
| ld_mon_i | input | 8 | Month to load, BCD |
| ld_year_i | input | 8 | Two-digit year to load, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, BCD, in the selected form |
| pm_o | output | 1 | 1 for the second half of the day |
| day_o | output | 8 | Day of month, BCD |
| wday_o | output | WD_W (3) | Day of week |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |

## Verification
The bench builds the block with its default seven-day week, so the weekday wraps after 6 and the weekday port is three bits wide. Reaching a year rollover by ticking alone would take millions of cycles. The bench therefore uses the load port to place the counters just below each boundary: end of minute, end of day, end of each month length, February in leap and common years, and end of century. A single tick then sends the full carry chain through the boundary. Random loads, which often pick last-values, are mixed with random mode switches. Together they exercise both hour forms at the 11-to-12 crossings and loads that coincide with a tick.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int BCD_W = 8;
  typedef logic [BCD_W-1:0] bcd8_t;

  function automatic logic [6:0] bcd2bin(bcd8_t v);
    return 7'(v[7:4] * 4'd10 + {3'd0, v[3:0]});
  endfunction

  function automatic bcd8_t bin2bcd(logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month; leap rule from the two-digit year only
  function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
    logic [6:0] yb;
    yb = bcd2bin(yr);
    case (mon)
      8'h02: return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_stage.sv
`timescale 1ns/1ps
module cal_bcd_stage
  import cal_pkg::*;
#(
  parameter bcd8_t FIRST = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  bcd8_t last_i,
  input  logic  load_i,
  input  bcd8_t load_val_i,
  output bcd8_t val_o,
  output logic  carry_o
);
  bcd8_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= FIRST;
    else if (load_i) q <= load_val_i;
    else if (en_i)   q <= (q == last_i) ? FIRST : bcd_inc(q);
  end

  assign val_o   = q;
  assign carry_o = en_i & (q == last_i);
endmodule

// File: rtl/cal_wday_stage.sv
`timescale 1ns/1ps
module cal_wday_stage #(
  parameter int DAYS = 7,
  localparam int WD_W = $clog2(DAYS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            load_i,
  input  logic [WD_W-1:0] load_val_i,
  output logic [WD_W-1:0] val_o
);
  localparam logic [WD_W-1:0] LAST = WD_W'(DAYS - 1);
  logic [WD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= load_val_i;
    else if (en_i)   q <= (q == LAST) ? '0 : q + 1'b1;
  end

  assign val_o = q;
endmodule

// File: rtl/cal_hour_fmt.sv
`timescale 1ns/1ps
module cal_hour_fmt
  import cal_pkg::*;
(
  input  bcd8_t hour24_i,
  input  logic  mode12_i,
  input  bcd8_t ld_hour_i,
  input  logic  ld_pm_i,
  output bcd8_t hour_o,
  output logic  pm_o,
  output bcd8_t ld_hour24_o
);
  logic [6:0] h_bin, h12_bin, l_bin, l24_bin;

  always_comb begin
    h_bin = bcd2bin(hour24_i);
    pm_o  = (h_bin >= 7'd12);
    if (h_bin == 7'd0)       h12_bin = 7'd12;
    else if (h_bin > 7'd12)  h12_bin = h_bin - 7'd12;
    else                     h12_bin = h_bin;
    hour_o = mode12_i ? bin2bcd(h12_bin) : hour24_i;

    l_bin = bcd2bin(ld_hour_i);
    if (l_bin == 7'd12) l24_bin = ld_pm_i ? 7'd12 : 7'd0;
    else                l24_bin = ld_pm_i ? l_bin + 7'd12 : l_bin;
    ld_hour24_o = mode12_i ? bin2bcd(l24_bin) : ld_hour_i;
  end
endmodule

// File: rtl/cal_time_counter.sv
`timescale 1ns/1ps
module cal_time_counter
  import cal_pkg::*;
#(
  parameter int DAYS_PER_WEEK = 7,
  localparam int WD_W = $clog2(DAYS_PER_WEEK)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            mode12_i,
  input  logic            load_i,
  input  logic [7:0]      ld_sec_i,
  input  logic [7:0]      ld_min_i,
  input  logic [7:0]      ld_hour_i,
  input  logic            ld_pm_i,
  input  logic [7:0]      ld_day_i,
  input  logic [WD_W-1:0] ld_wday_i,
  input  logic [7:0]      ld_mon_i,
  input  logic [7:0]      ld_year_i,
  output logic [7:0]      sec_o,
  output logic [7:0]      min_o,
  output logic [7:0]      hour_o,
  output logic            pm_o,
  output logic [7:0]      day_o,
  output logic [WD_W-1:0] wday_o,
  output logic [7:0]      mon_o,
  output logic [7:0]      year_o
);
  logic  step;
  logic  c_sec, c_min, c_hour, c_day, c_mon, c_year;
  bcd8_t hour24, ld_hour24, mlen;

  assign step = tick_i & ~load_i;  // load wins over tick
  assign mlen = month_last(mon_o, year_o);

  cal_bcd_stage #(.FIRST(8'h00)) u_sec (
    .clk_i, .rst_ni, .en_i(step), .last_i(8'h59), .load_i,
    .load_val_i(ld_sec_i), .val_o(sec_o), .carry_o(c_sec));

  cal_bcd_stage #(.FIRST(8'h00)) u_min (
    .clk_i, .rst_ni, .en_i(c_sec), .last_i(8'h59), .load_i,
    .load_val_i(ld_min_i), .val_o(min_o), .carry_o(c_min));

  cal_bcd_stage #(.FIRST(8'h00)) u_hour (
    .clk_i, .rst_ni, .en_i(c_min), .last_i(8'h23), .load_i,
    .load_val_i(ld_hour24), .val_o(hour24), .carry_o(c_hour));

  cal_bcd_stage #(.FIRST(8'h01)) u_day (
    .clk_i, .rst_ni, .en_i(c_hour), .last_i(mlen), .load_i,
    .load_val_i(ld_day_i), .val_o(day_o), .carry_o(c_day));

  cal_bcd_stage #(.FIRST(8'h01)) u_mon (
    .clk_i, .rst_ni, .en_i(c_day), .last_i(8'h12), .load_i,
    .load_val_i(ld_mon_i), .val_o(mon_o), .carry_o(c_mon));

  cal_bcd_stage #(.FIRST(8'h00)) u_year (
    .clk_i, .rst_ni, .en_i(c_mon), .last_i(8'h99), .load_i,
    .load_val_i(ld_year_i), .val_o(year_o), .carry_o(c_year));

  cal_wday_stage #(.DAYS(DAYS_PER_WEEK)) u_wday (
    .clk_i, .rst_ni, .en_i(c_hour), .load_i,
    .load_val_i(ld_wday_i), .val_o(wday_o));

  cal_hour_fmt u_fmt (
    .hour24_i(hour24), .mode12_i, .ld_hour_i, .ld_pm_i,
    .hour_o, .pm_o, .ld_hour24_o(ld_hour24));

  p_min_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_sec && !load_i |=> $stable(min_o));

  p_hour_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour24 <= 8'h23);

  p_hour12_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode12_i |-> (hour_o != 8'h00) && (hour_o <= 8'h12));

  p_day_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_o >= 8'h01) && (day_o <= mlen));

  p_year_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_year |=> (year_o == 8'h00) && (mon_o == 8'h01) && (day_o == 8'h01));

  p_wday_moves_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_day |=> wday_o != $past(wday_o));

  p_load_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_o == $past(ld_sec_i)) && (day_o == $past(ld_day_i)) &&
               (year_o == $past(ld_year_i)));

  p_idle_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour24) &&
                           $stable(day_o) && $stable(mon_o) && $stable(year_o) &&
                           $stable(wday_o));
endmodule

// File: tb/cal_time_counter_tb.sv
`timescale 1ns/1ps
module cal_time_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, mode12 = 1'b0, load = 1'b0, ld_pm = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_day = 8'h01;
  logic [7:0] ld_mon = 8'h01, ld_year = '0;
  logic [2:0] ld_wday = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
  logic [2:0] wday_o;
  logic pm_o;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  int s = 0, m = 0, h = 0, d = 1, mo = 1, y = 0, wd = 0;
  int ns, nm, nh, nd, nmo, ny, nwd;

  always #5 clk = ~clk;

  cal_time_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode12_i(mode12), .load_i(load),
    .ld_sec_i(ld_sec), .ld_min_i(ld_min), .ld_hour_i(ld_hour), .ld_pm_i(ld_pm),
    .ld_day_i(ld_day), .ld_wday_i(ld_wday), .ld_mon_i(ld_mon), .ld_year_i(ld_year),
    .sec_o, .min_o, .hour_o, .pm_o, .day_o, .wday_o, .mon_o, .year_o);

  function automatic logic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int h12(int hv);
    if (hv == 0) return 12;
    if (hv > 12) return hv - 12;
    return hv;
  endfunction

  function automatic int mdays(int mm, int yy);
    if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
    if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; wd = (wd + 1) % 7; d++;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    check(tag == "" ? "R2 sec" : tag, int'(sec_o), int'(bcd(s)));
    check(tag == "" ? "R3 min" : tag, int'(min_o), int'(bcd(m)));
    check(tag == "" ? (mode12 ? "R5 hour" : "R4 hour") : tag, int'(hour_o),
          int'(bcd(mode12 ? h12(h) : h)));
    check(tag == "" ? "R5 pm" : tag, int'(pm_o), int'(h >= 12));
    check(tag == "" ? "R7 day" : tag, int'(day_o), int'(bcd(d)));
    check(tag == "" ? "R9 month" : tag, int'(mon_o), int'(bcd(mo)));
    check(tag == "" ? "R9 year" : tag, int'(year_o), int'(bcd(y)));
    check(tag == "" ? "R10 wday" : tag, int'(wday_o), wd);
  endtask

  // one clock; inputs driven at negedge, outputs compared at the next negedge
  task automatic cyc(bit tk, bit ld, string tag);
    tick = tk; load = ld;
    @(posedge clk);
    if (ld) begin s = ns; m = nm; h = nh; d = nd; mo = nmo; y = ny; wd = nwd; end
    else if (tk) model_tick();
    @(negedge clk);
    tick = 1'b0; load = 1'b0;
    cmp_all(tag);
  endtask

  task automatic put(int ps, int pm_, int ph, int pd, int pmo, int py, int pwd);
    ns = ps; nm = pm_; nh = ph; nd = pd; nmo = pmo; ny = py; nwd = pwd;
    ld_sec = bcd(ps); ld_min = bcd(pm_); ld_day = bcd(pd);
    ld_mon = bcd(pmo); ld_year = bcd(py); ld_wday = 3'(pwd);
    ld_hour = bcd(mode12 ? h12(ph) : ph);
    ld_pm = (ph >= 12);
  endtask

  task automatic set_mode(bit md, string tag);
    mode12 = md;
    #1;
    cmp_all(tag);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240117));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1");
    set_mode(1'b1, "R1");
    set_mode(1'b0, "R1");

    cyc(1'b0, 1'b0, "R12");
    cyc(1'b1, 1'b0, "R2");

    // end of century rollover
    put(59, 59, 23, 31, 12, 99, 6); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R9");

    // leap and common February
    put(59, 59, 23, 28, 2, 24, 3); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R8");
    put(59, 59, 23, 28, 2, 23, 3); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R8");
    put(59, 59, 23, 29, 2, 0, 1); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R8");

    // 30- and 31-day months
    put(59, 59, 23, 30, 4, 7, 2); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R7");
    put(59, 59, 23, 30, 1, 7, 2); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R7");
    cyc(1'b1, 1'b0, "R7");

    // 12-hour crossings, loaded in 12-hour form
    set_mode(1'b1, "R6");
    put(59, 59, 11, 5, 5, 5, 5); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R5");
    put(59, 59, 23, 5, 5, 5, 5); cyc(1'b0, 1'b1, "R11");
    cyc(1'b1, 1'b0, "R5");

    // mode change only re-presents the hour
    put(0, 30, 15, 9, 9, 9, 4); cyc(1'b0, 1'b1, "R11");
    set_mode(1'b0, "R6");
    set_mode(1'b1, "R6");
    set_mode(1'b0, "R6");

    // load coinciding with a tick
    put(10, 20, 8, 17, 6, 41, 2); cyc(1'b1, 1'b1, "R11");
    repeat (4) cyc(1'b0, 1'b0, "R12");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 6) begin
        int ts, tm, th, tmo, ty, td;
        ts = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
        tm = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
        th = ($urandom % 3 == 0) ? 23 : (($urandom % 2 == 0) ? 11 : int'($urandom % 24));
        tmo = 1 + int'($urandom % 12);
        ty = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
        td = ($urandom % 2 == 0) ? mdays(tmo, ty) : 1 + int'($urandom % mdays(tmo, ty));
        put(ts, tm, th, td, tmo, ty, int'($urandom % 7));
        cyc(($urandom % 4 == 0), 1'b1, "R11");
      end else if (r < 10) begin
        set_mode(~mode12, "R6");
      end else begin
        cyc(($urandom % 10 != 0), 1'b0, "");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule